// File: doc/BRIEF.md
# Colored Button Code Lock

This block is a synchronous controller that releases a door latch only after an arming press on a start button followed by an exact ordered sequence of colored button presses. The sequence length and its contents are fixed when the block is elaborated, and the default is red, blue, green, red. Each button input is expected to arrive as a one-cycle pulse from upstream shaping logic. A separate strobe marks the cycles in which some colored button is being pressed.

While armed, the controller waits for each colored press. A press that is exactly the single expected button moves it one step forward. A press that shows no button, the wrong button, or several buttons at once throws it back to idle, where a new start press is needed. Once the last button of the code is accepted, the unlock output is high for exactly one cycle and the controller returns to idle.

Top module: `code_lock`

## Requirements
- R1: While rst_n is low the controller is idle and unlock_o is 0; the first sequence after reset must begin with a start press.
- R2: In idle the controller stays idle unless start_i is 1 at a clock edge, and a start_i of 1 arms it with no keys yet accepted; colored presses in idle have no effect.
- R3: While armed, a cycle with any_i=0 leaves the progress unchanged whatever btn_i holds.
- R4: While armed, a press (any_i=1) whose btn_i is exactly the one-hot code of the expected key advances by one key; btn_i bit 0 is red, bit 1 green, bit 2 blue.
- R5: While armed, a press (any_i=1) whose btn_i is not exactly the expected one-hot value (zero, another key, or several keys including all at once) returns the controller to idle.
- R6: Accepting the final key raises unlock_o for exactly one cycle, after which the controller is idle regardless of its inputs.
- R7: start_i has no effect while the controller is armed or unlocking.
- R8: With default parameters the code is red, blue, green, red, key 0 being the first key to enter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle start button pulse |
| any_i | input | 1 | High in a cycle where a colored press is presented |
| btn_i | input | NUM_KEYS | Colored buttons, bit 0 red, bit 1 green, bit 2 blue |
| unlock_o | output | 1 | One-cycle unlock pulse |

## Verification
The bench builds the lock with its default parameters: three keys and the four-key code red, blue, green, red. Because red opens and closes that code, a repeated red in the wrong position, a sequence aborted one key short, and restarts right after a pulse all become reachable. Random presses mixed with wrong, empty and all-buttons presses, stray start pulses and a reset in mid-sequence are compared cycle by cycle against a reference model of the transition rules.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int KEY_RED   = 0;
  localparam int KEY_GREEN = 1;
  localparam int KEY_BLUE  = 2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_ARMED = 2'b01,
    PH_OPEN  = 2'b10
  } phase_e;

endpackage

// File: rtl/lock_press_qual.sv
// Compares a colored press against the key expected at the current progress.
module lock_press_qual #(
  parameter int NUM_KEYS = 3,
  parameter int CODE_LEN = 4,
  parameter int KEY_W    = 2,
  parameter int PROG_W   = 2,
  parameter logic [CODE_LEN*KEY_W-1:0] CODE = '0
) (
  input  logic                any_i,
  input  logic [NUM_KEYS-1:0] btn_i,
  input  logic [PROG_W-1:0]   idx_i,
  output logic                hit_o,
  output logic                miss_o
);

  logic [NUM_KEYS-1:0] exp_tab [CODE_LEN];
  logic [NUM_KEYS-1:0] exp_sel;

  for (genvar k = 0; k < CODE_LEN; k++) begin : g_tab
    assign exp_tab[k] = NUM_KEYS'(1) << CODE[k*KEY_W +: KEY_W];
  end

  always_comb begin
    exp_sel = '0;
    for (int k = 0; k < CODE_LEN; k++) begin
      if (idx_i == PROG_W'(k)) exp_sel = exp_tab[k];
    end
  end

  assign hit_o  = any_i && (|exp_sel) && (btn_i == exp_sel);
  assign miss_o = any_i && !hit_o;

endmodule

// File: rtl/lock_seq_fsm.sv
// Phase register plus progress counter; next-state logic kept apart from the flops.
module lock_seq_fsm
  import lock_pkg::*;
#(
  parameter int CODE_LEN = 4,
  parameter int PROG_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hit_i,
  input  logic              miss_i,
  output phase_e            phase_o,
  output logic [PROG_W-1:0] prog_o,
  output logic              unlock_o
);

  localparam logic [PROG_W-1:0] LAST = PROG_W'(CODE_LEN - 1);

  phase_e            phase_q, phase_d;
  logic [PROG_W-1:0] prog_q, prog_d;
  logic              upd_en;

  always_comb begin
    phase_d = phase_q;
    prog_d  = prog_q;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_ARMED;
          prog_d  = '0;
        end
      end
      PH_ARMED: begin
        if (hit_i) begin
          if (prog_q == LAST) phase_d = PH_OPEN;
          else                prog_d  = prog_q + PROG_W'(1);
        end else if (miss_i) begin
          phase_d = PH_IDLE;
        end
      end
      PH_OPEN: phase_d = PH_IDLE;
      default: begin
        phase_d = PH_IDLE;
        prog_d  = '0;
      end
    endcase
  end

  assign upd_en = (phase_d != phase_q) || (prog_d != prog_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      prog_q  <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      prog_q  <= prog_d;
    end
  end

  assign phase_o  = phase_q;
  assign prog_o   = prog_q;
  assign unlock_o = (phase_q == PH_OPEN);

endmodule

// File: rtl/code_lock.sv
module code_lock
  import lock_pkg::*;
#(
  parameter int NUM_KEYS = 3,
  parameter int CODE_LEN = 4,
  parameter logic [CODE_LEN*((NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1)-1:0] CODE =
    {2'(KEY_RED), 2'(KEY_GREEN), 2'(KEY_BLUE), 2'(KEY_RED)}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                any_i,
  input  logic [NUM_KEYS-1:0] btn_i,
  output logic                unlock_o
);

  localparam int KEY_W  = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;
  localparam int PROG_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;

  logic              hit, miss;
  phase_e            cur_phase;
  logic [PROG_W-1:0] cur_prog;

  lock_press_qual #(
    .NUM_KEYS(NUM_KEYS), .CODE_LEN(CODE_LEN), .KEY_W(KEY_W),
    .PROG_W(PROG_W), .CODE(CODE)
  ) u_qual (
    .any_i (any_i),
    .btn_i (btn_i),
    .idx_i (cur_prog),
    .hit_o (hit),
    .miss_o(miss)
  );

  lock_seq_fsm #(
    .CODE_LEN(CODE_LEN), .PROG_W(PROG_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .hit_i   (hit),
    .miss_i  (miss),
    .phase_o (cur_phase),
    .prog_o  (cur_prog),
    .unlock_o(unlock_o)
  );

endmodule

// File: rtl/code_lock_chk.sv
module code_lock_chk
  import lock_pkg::*;
#(
  parameter int NUM_KEYS = 3,
  parameter int CODE_LEN = 4,
  parameter int KEY_W    = 2,
  parameter int PROG_W   = 2,
  parameter logic [CODE_LEN*KEY_W-1:0] CODE = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                any_i,
  input logic [NUM_KEYS-1:0] btn_i,
  input logic                unlock_o,
  input phase_e              phase,
  input logic [PROG_W-1:0]   prog
);

  localparam logic [PROG_W-1:0] LAST = PROG_W'(CODE_LEN - 1);

  function automatic logic [NUM_KEYS-1:0] expected_oh(input logic [PROG_W-1:0] p);
    return NUM_KEYS'(1) << CODE[int'(p)*KEY_W +: KEY_W];
  endfunction

  logic good_press;
  assign good_press = any_i && (btn_i == expected_oh(prog));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !start_i) |=> (phase == PH_IDLE));

  // R2
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start_i) |=> (phase == PH_ARMED && prog == '0));

  // R3
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ARMED && !any_i) |=> ($stable(phase) && $stable(prog)));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ARMED && good_press && prog != LAST)
      |=> (phase == PH_ARMED && prog == $past(prog) + PROG_W'(1)));

  // R5
  wrong_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ARMED && any_i && !good_press) |=> (phase == PH_IDLE));

  // R6
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_o |=> (!unlock_o && phase == PH_IDLE));

  // R6
  unlock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_o) |-> $past(phase == PH_ARMED && good_press && prog == LAST));

endmodule

bind code_lock code_lock_chk #(
  .NUM_KEYS(NUM_KEYS), .CODE_LEN(CODE_LEN), .KEY_W(KEY_W),
  .PROG_W(PROG_W), .CODE(CODE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .any_i   (any_i),
  .btn_i   (btn_i),
  .unlock_o(unlock_o),
  .phase   (cur_phase),
  .prog    (cur_prog)
);

// File: tb/code_lock_bench.sv
`timescale 1ns/1ps
module code_lock_bench;

  localparam logic [2:0] RED   = 3'b001;
  localparam logic [2:0] GREEN = 3'b010;
  localparam logic [2:0] BLUE  = 3'b100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic       any_i;
  logic [2:0] btn_i;
  logic       unlock_o;

  int n_vec  = 0;
  int n_fail = 0;
  int m_ph   = 0;   // 0 idle, 1 armed, 2 open
  int m_prog = 0;
  string cur_tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  code_lock u_code_lock (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .any_i(any_i), .btn_i(btn_i), .unlock_o(unlock_o)
  );

  // R8: default code red, blue, green, red
  function automatic logic [2:0] key_oh(input int k);
    case (k)
      0: return RED;
      1: return BLUE;
      2: return GREEN;
      default: return RED;
    endcase
  endfunction

  task automatic model_step(input bit s, input bit a, input logic [2:0] b);
    case (m_ph)
      0: if (s) begin m_ph = 1; m_prog = 0; end
      1: if (a) begin
           if (b == key_oh(m_prog)) begin
             if (m_prog == 3) m_ph = 2;
             else m_prog = m_prog + 1;
           end else m_ph = 0;
         end
      default: m_ph = 0;
    endcase
  endtask

  task automatic compare();
    logic expv;
    expv = (m_ph == 2);
    n_vec++;
    if (unlock_o !== expv) begin
      n_fail++;
      $display("FAIL %s: unlock_o=%b expected %b at %0t", cur_tag, unlock_o, expv, $time);
    end
  endtask

  task automatic cyc(input bit s, input bit a, input logic [2:0] b, input string tag);
    @(negedge clk);
    compare();
    start_i = s; any_i = a; btn_i = b;
    model_step(s, a, b);
    cur_tag = tag;
  endtask

  task automatic press_code(input string tag);
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, key_oh(k), tag);
  endtask

  initial begin
    int unused_seed;
    int r;
    unused_seed = $urandom(32'h5EED1);
    rst_n = 1'b0; start_i = 1'b0; any_i = 1'b0; btn_i = 3'b000;
    repeat (3) begin
      @(negedge clk);
      cur_tag = "R1";
      compare();
    end
    rst_n = 1'b1;

    // R1: press code without start after reset: no unlock
    press_code("R1");
    cyc(0, 0, 3'b000, "R1");
    // R2: colored presses in idle are ignored, then start arms
    cyc(0, 1, RED, "R2");
    cyc(1, 0, 3'b000, "R2");
    press_code("R4");
    cyc(0, 0, 3'b000, "R6");
    cyc(1, 0, 3'b000, "R6");
    // R3: junk on buttons with any_i low, and idle gaps between keys
    cyc(1, 0, 3'b000, "R2");
    cyc(0, 0, 3'b111, "R3");
    cyc(0, 1, RED, "R3");
    cyc(0, 0, GREEN, "R3");
    cyc(0, 1, BLUE, "R3");
    cyc(0, 0, 3'b101, "R3");
    cyc(0, 1, GREEN, "R3");
    cyc(1, 0, 3'b000, "R7");
    cyc(0, 1, RED, "R7");
    cyc(1, 0, 3'b000, "R6");
    cyc(0, 0, 3'b000, "R6");
    // R5: all buttons at once
    cyc(1, 0, 3'b000, "R2");
    cyc(0, 1, 3'b111, "R5");
    cyc(0, 1, BLUE, "R5");
    cyc(0, 1, GREEN, "R5");
    cyc(0, 1, RED, "R5");
    cyc(0, 0, 3'b000, "R5");
    // R5: any_i high with no button, then wrong repeated red
    cyc(1, 0, 3'b000, "R2");
    cyc(0, 1, RED, "R4");
    cyc(0, 1, 3'b000, "R5");
    cyc(0, 0, 3'b000, "R5");
    cyc(1, 0, 3'b000, "R2");
    cyc(0, 1, RED, "R4");
    cyc(0, 1, BLUE, "R4");
    cyc(0, 1, RED, "R5");
    cyc(0, 1, RED, "R5");
    cyc(0, 0, 3'b000, "R5");
    // R7: start in the middle does not restart progress
    cyc(1, 0, 3'b000, "R2");
    cyc(0, 1, RED, "R7");
    cyc(1, 0, 3'b000, "R7");
    cyc(0, 1, BLUE, "R7");
    cyc(0, 1, GREEN, "R7");
    cyc(0, 1, RED, "R7");
    cyc(0, 0, 3'b000, "R6");
    // R1: reset mid-sequence
    cyc(1, 0, 3'b000, "R2");
    cyc(0, 1, RED, "R4");
    cyc(0, 1, BLUE, "R4");
    @(negedge clk);
    compare();
    rst_n = 1'b0; start_i = 0; any_i = 0; btn_i = 3'b000;
    m_ph = 0; m_prog = 0; cur_tag = "R1";
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    cyc(0, 1, GREEN, "R1");
    cyc(0, 1, RED, "R1");
    cyc(0, 0, 3'b000, "R1");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      r = int'($urandom % 100);
      if (m_ph == 1 && r < 55)
        cyc(0, 1, key_oh(m_prog), "R4");
      else if (m_ph == 1 && r < 70)
        cyc(r[0], 0, 3'($urandom), "R3");
      else if (m_ph == 1 && r < 80)
        cyc(1, 0, 3'b000, "R7");
      else if (m_ph == 1)
        cyc(0, 1, 3'($urandom), "R5");
      else if (r < 50)
        cyc(1, r[1], 3'($urandom), "R2");
      else
        cyc(0, r[2], 3'($urandom), "R6");
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule